// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block is a down-counting reload timer that advances on a 32768 Hz enable pulse presented on the `tick` input, while the whole design runs on the faster system clock. Each time the running count expires, a sticky event flag is set. An interrupt line follows that flag whenever the interrupt enable is on. In auto-reload mode the count restarts from the reload value, so the flag fires at a fixed rate. Loading the reload value with 0x8000 shifted right by n gives 2^n expiries per second. In single-shot mode the timer stops itself after one expiry.

Software configures the timer through byte-wide registers. There is one control byte and one reload byte per eight bits of count. The running count can be read back, one byte per address, and any write to a count address clears the count. Control bits 7..4 are reserved for a neighbouring watchdog function: they read as zero and ignore writes. Register reads return data one cycle after the read strobe.

Top module: `tick_timer`

## Requirements
- R1: After reset the control byte, both reload bytes, the count, `rdata` and `irq` are all zero.
- R2: The control byte is at 0x10 with run in bit 3, interrupt enable in bit 2, event flag in bit 1 and auto-reload mode in bit 0. Bits 3, 2 and 0 read back as written. Bits 7..4 always read 0 and writes to them have no effect.
- R3: The reload value is written and read as bytes, with the low byte at 0x12 and the high byte at 0x13.
- R4: While run is 1, each cycle with `tick` high lowers a count above 1 by exactly one. Without `tick`, or with run at 0, the count does not change.
- R5: A tick that arrives when run is 1 and the count equals 1 is an expiry. It sets the event flag. In auto-reload mode it loads the count with the reload value, so expiries recur every reload-value ticks.
- R6: A tick that arrives when run is 1 and the count is 0 loads the reload value without setting the flag.
- R7: In single-shot mode (bit 0 = 0), an expiry clears run and leaves the count at 0. Later ticks then change neither the count nor the flag.
- R8: Writing 1 to control bit 1 clears the flag, and writing 0 there leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag ends set.
- R9: `irq` is high exactly when the flag and the interrupt enable are both 1, and it changes in the same cycle as those bits.
- R10: Any write to a count address (0x20, 0x21) sets the count to 0, whatever the data and whether or not a tick arrives in that cycle.
- R11: The count reads back with the low byte at 0x20 and the high byte at 0x21. Unmapped addresses read 0. `rdata` is updated on the clock edge that samples `rd_en` and holds between reads.
- R12: With a reload value of 0 the timer never expires, and the count stays at 0.
- R13: For a reload value of 0x8000 >> n, the count steps R, R-1, …, 1 and then expires and restarts at R, with R = 0x8000 >> n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32768 Hz count enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Timer interrupt, flag AND interrupt enable |

## Verification
The hardest case to reach from the ports is a clearing write to the flag that lands in the very cycle of an expiry. To get there, the bench loads a reload value of 2 and ticks until the count sits at 1. It then raises `tick` and the flag-clearing control write on the same clock, and checks that the flag survives. The auto-reload period is swept over reload values 0x8000 >> n for n from 4 to 15. For each value, the bench predicts the count after several tick totals before and after the first expiry, arithmetically.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Control byte bits 3..0; upper nibble is reserved and reads zero.
  typedef struct packed {
    logic run;
    logic ien;
    logic flag;
    logic mode;
  } tmr_ctrl_t;

  localparam int CTRL_RUN_BIT  = 3;
  localparam int CTRL_IEN_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 1;
  localparam int CTRL_MODE_BIT = 0;

  function automatic logic [7:0] ctrl_to_byte(tmr_ctrl_t c);
    return {4'b0000, c};
  endfunction

endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int CTRL_ADDR   = 'h10,
  parameter int RELOAD_ADDR = 'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              expire,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              irq
);
  localparam int NB = CNT_W / 8;

  tmr_ctrl_t ctrl_q, ctrl_nxt;
  logic [CNT_W-1:0] reload_q;
  logic irq_q;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) begin
      ctrl_nxt.run  = wdata[CTRL_RUN_BIT];
      ctrl_nxt.ien  = wdata[CTRL_IEN_BIT];
      ctrl_nxt.mode = wdata[CTRL_MODE_BIT];
      if (wdata[CTRL_FLAG_BIT]) ctrl_nxt.flag = 1'b0;
    end
    // hardware event has priority over a software clear
    if (expire) begin
      ctrl_nxt.flag = 1'b1;
      if (!ctrl_q.mode) ctrl_nxt.run = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      irq_q  <= ctrl_nxt.flag && ctrl_nxt.ien;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (wr_en && (addr == ADDR_W'(RELOAD_ADDR + i)))
          reload_q[i*8 +: 8] <= wdata;
      end
    end
  end

  assign ctrl   = ctrl_q;
  assign reload = reload_q;
  assign irq    = irq_q;
endmodule

// File: rtl/tt_count.sv
module tt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             mode,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic step;

  assign step   = tick && run && !clr;
  assign expire = step && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (cnt_q == '0)
        cnt_q <= reload;
      else if (cnt_q == ONE)
        cnt_q <= mode ? reload : '0;
      else
        cnt_q <= cnt_q - ONE;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/tt_rdmux.sv
module tt_rdmux
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int CTRL_ADDR   = 'h10,
  parameter int RELOAD_ADDR = 'h12,
  parameter int COUNT_ADDR  = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  tmr_ctrl_t         ctrl,
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  count,
  output logic [7:0]        rdata
);
  localparam int NB = CNT_W / 8;

  logic [7:0] sel;
  logic [7:0] rdata_q;

  always_comb begin
    sel = 8'h00;
    if (addr == ADDR_W'(CTRL_ADDR)) sel = ctrl_to_byte(ctrl);
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(RELOAD_ADDR + i)) sel = reload[i*8 +: 8];
      if (addr == ADDR_W'(COUNT_ADDR + i))  sel = count[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= sel;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int CTRL_ADDR   = 'h10,
  parameter int RELOAD_ADDR = 'h12,
  parameter int COUNT_ADDR  = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam int NB = CNT_W / 8;

  tmr_ctrl_t        ctrl_w;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] count_w;
  logic             expire_w;
  logic             clr_w;

  always_comb begin
    clr_w = 1'b0;
    for (int i = 0; i < NB; i++)
      if (wr_en && (addr == ADDR_W'(COUNT_ADDR + i))) clr_w = 1'b1;
  end

  tt_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .RELOAD_ADDR(RELOAD_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire_w), .ctrl(ctrl_w), .reload(reload_w), .irq(irq)
  );

  tt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .run(ctrl_w.run), .mode(ctrl_w.mode),
    .clr(clr_w), .reload(reload_w), .count(count_w), .expire(expire_w)
  );

  tt_rdmux #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .RELOAD_ADDR(RELOAD_ADDR), .COUNT_ADDR(COUNT_ADDR)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .ctrl(ctrl_w),
    .reload(reload_w), .count(count_w), .rdata(rdata)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             clr,
  input logic             run,
  input logic             ien,
  input logic             flag,
  input logic             mode,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             irq
);
  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);

  p_autoreload_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && mode) |=> (count == $past(reload)));

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && !mode) |=> (!run && count == '0));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ien));

  p_count_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  p_count_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !clr && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

  p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(tick && run)) |=> $stable(count));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .clr(clr_w),
  .run(ctrl_w.run), .ien(ctrl_w.ien), .flag(ctrl_w.flag), .mode(ctrl_w.mode),
  .expire(expire_w), .count(count_w), .reload(reload_w), .irq(irq)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_count(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(8'h20, lo);
    rd(8'h21, hi);
    c = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input logic [15:0] rl, input logic [7:0] c);
    wr(8'h10, 8'h02);
    wr(8'h20, 8'h00);
    wr(8'h12, rl[7:0]);
    wr(8'h13, rl[15:8]);
    wr(8'h10, c);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] c;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(8'h10, b); check("R1 ctrl", {8'd0, b}, 16'h0000);
    rd(8'h12, b); check("R1 reload lo", {8'd0, b}, 16'h0000);
    rd(8'h13, b); check("R1 reload hi", {8'd0, b}, 16'h0000);
    rd_count(c);  check("R1 count", c, 16'h0000);

    // R2 control readback, reserved bits
    wr(8'h10, 8'hF5);
    rd(8'h10, b); check("R2 ctrl readback", {8'd0, b}, 16'h0005);
    wr(8'h10, 8'h00);

    // R3 reload bytes
    wr(8'h12, 8'h34); wr(8'h13, 8'h12);
    rd(8'h12, b); check("R3 reload lo", {8'd0, b}, 16'h0034);
    rd(8'h13, b); check("R3 reload hi", {8'd0, b}, 16'h0012);
    // R11 unmapped
    rd(8'h11, b); check("R11 unmapped", {8'd0, b}, 16'h0000);

    // R6 load from zero, R4 decrement and hold
    setup(16'd5, 8'h09);
    ticks(1);
    rd_count(c); check("R6 load", c, 16'd5);
    rd(8'h10, b); check("R6 no flag", {8'd0, b}, 16'h0009);
    ticks(2);
    rd_count(c); check("R4 decrement", c, 16'd3);
    repeat (5) @(negedge clk);
    rd_count(c); check("R4 hold no tick", c, 16'd3);
    wr(8'h10, 8'h01);
    ticks(3);
    rd_count(c); check("R4 hold not running", c, 16'd3);
    wr(8'h10, 8'h09);
    ticks(2);
    rd_count(c); check("R4 reach one", c, 16'd1);
    rd(8'h10, b); check("R5 not yet", {8'd0, b}, 16'h0009);
    ticks(1);
    rd_count(c); check("R5 reload", c, 16'd5);
    rd(8'h10, b); check("R5 flag", {8'd0, b}, 16'h000B);
    check("R9 irq masked", {15'd0, irq}, 16'd0);

    // R8 / R9
    wr(8'h10, 8'h0D);
    rd(8'h10, b); check("R8 write0 keeps", {8'd0, b}, 16'h000F);
    check("R9 irq on", {15'd0, irq}, 16'd1);
    wr(8'h10, 8'h0F);
    rd(8'h10, b); check("R8 w1c", {8'd0, b}, 16'h000D);
    check("R9 irq off", {15'd0, irq}, 16'd0);

    // R10 clear with nonzero data
    wr(8'h20, 8'hA5);
    rd_count(c); check("R10 clear", c, 16'd0);

    // R8 collision: expiry and clearing write together
    setup(16'd2, 8'h0D);
    ticks(2);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h10; wdata = 8'h0F;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(8'h10, b); check("R8 set wins", {8'd0, b}, 16'h000F);
    check("R9 irq collision", {15'd0, irq}, 16'd1);
    rd_count(c); check("R5 reload collision", c, 16'd2);

    // R10 clear with a simultaneous tick
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h21; wdata = 8'h7E;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd_count(c); check("R10 clear beats tick", c, 16'd0);

    // R7 single shot
    setup(16'd3, 8'h08);
    ticks(4);
    rd(8'h10, b); check("R7 stopped", {8'd0, b}, 16'h0002);
    rd_count(c); check("R7 count zero", c, 16'd0);
    wr(8'h10, 8'h00);
    ticks(5);
    rd(8'h10, b); check("R7 stays stopped", {8'd0, b}, 16'h0002);
    rd_count(c); check("R7 count stays", c, 16'd0);

    // R12 reload zero
    setup(16'd0, 8'h09);
    ticks(10);
    rd(8'h10, b); check("R12 no expiry", {8'd0, b}, 16'h0009);
    rd_count(c); check("R12 count", c, 16'd0);

    // R13 rate sweep
    for (int n = 4; n < 16; n++) begin
      int r;
      int m;
      r = 32'h8000 >> n;
      setup(16'(r), 8'h09);
      ticks(r);
      rd_count(c); check($sformatf("R13 n=%0d pre", n), c, 16'd1);
      rd(8'h10, b); check($sformatf("R13 n=%0d noflag", n), {8'd0, b}, 16'h0009);
      ticks(1);
      rd_count(c); check($sformatf("R13 n=%0d reload", n), c, 16'(r));
      rd(8'h10, b); check($sformatf("R13 n=%0d flag", n), {8'd0, b}, 16'h000B);
      m = r + r / 2;
      ticks(m);
      rd_count(c); check($sformatf("R13 n=%0d phase", n), c, 16'(r - (m % r)));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule